// File: doc/BRIEF.md
# Dual-Register Bus Transceiver

This block connects two parallel buses, A and B. Each direction has three parts: a capture register on its own clock, a select that chooses between the live value of the source bus and the captured value, and an output enable for the far bus. A rising edge on the A-side capture clock loads the current A bus value. A rising edge on the B-side capture clock loads the B bus value. The capture happens whatever the selects are set to.

There are no internal tri-states. Each bus appears at the ports as three signals: an externally driven value with a flag saying whether an outside driver is present, the value the block drives, and the block's own drive flag. The block resolves each bus internally. An outside driver wins. Otherwise the bus carries whatever the block drives. When neither is present, the bus keeps the value it had, which is sampled on a free-running clock.

With both selects on live data and both drive flags set, the two directions form a loop. In that loop a bus driven from outside is copied onto the other bus. When neither bus is driven from outside, both keep their last value.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On a rising edge of `clk_ab` the resolved A bus value is loaded into the A-side register, whether `sel_ab` is 0 or 1. With `sel_ab` = 1, `b_out` shows that register.
- R2: On a rising edge of `clk_ba` the resolved B bus value is loaded into the B-side register, whether `sel_ba` is 0 or 1. With `sel_ba` = 1, `a_out` shows that register.
- R3: With `rst` = 1, a capture clock edge clears that side's register to zero, and each rising edge of `clk` clears both hold values to zero.
- R4: With `sel_ab` = 0, `b_out` equals the resolved A bus. When `a_ext_en` = 1 that is `a_in`.
- R5: With `sel_ba` = 0, `a_out` equals the resolved B bus. When `b_ext_en` = 1 that is `b_in`.
- R6: `b_oe` is 1 exactly when `en_ab` = 1 (active high). `a_oe` is 1 exactly when `en_ba_n` = 0 (active low).
- R7: With both selects 0, both drive flags set and neither outside driver present, `a_out` and `b_out` keep the values they had when the last outside driver was released.
- R8: In the same loop setting with exactly one outside driver present, both `a_out` and `b_out` equal that driver's value.
- R9: A register does not change while its source bus changes and no edge arrives on its capture clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; samples the bus hold values |
| rst | input | 1 | Synchronous active-high reset |
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| en_ab | input | 1 | Active-high enable for driving bus B |
| en_ba_n | input | 1 | Active-low enable for driving bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A bus, 1 A-side register |
| sel_ba | input | 1 | Source for bus A: 0 live B bus, 1 B-side register |
| a_in | input | WIDTH | Value driven onto bus A from outside |
| a_ext_en | input | 1 | An outside driver is present on bus A |
| a_out | output | WIDTH | Value the block drives onto bus A |
| a_oe | output | 1 | The block drives bus A |
| b_in | input | WIDTH | Value driven onto bus B from outside |
| b_ext_en | input | 1 | An outside driver is present on bus B |
| b_out | output | WIDTH | Value the block drives onto bus B |
| b_oe | output | 1 | The block drives bus B |

## Verification
The bench builds the block with the default WIDTH of 8. This lets it use complementary and alternating byte patterns that would show any swapped or stuck bit lane between the two buses. At this width the bench can step through all sixteen combinations of the two selects and two enables, with distinct values on each bus. It can also sweep the hold loop through driven, released and re-driven phases from either side.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

    parameter int unsigned DXR_WIDTH = 8;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_A    = 0;
    localparam int unsigned SIDE_B    = 1;

    // Source for the path that reads a bus and drives the opposite one
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    // Control view of one bus side
    typedef struct packed {
        logic     ext_en;    // outside driver present on this bus
        logic     drive_en;  // block drives this bus
        src_sel_e sel;       // source choice of the path reading this bus
    } side_ctl_t;

    function automatic int unsigned far_side(input int unsigned side);
        return NUM_SIDES - 1 - side;
    endfunction

endpackage

// File: rtl/dxr_capture.sv
module dxr_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dxr_resolve.sv
module dxr_resolve
    import dxr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  side_ctl_t    near_ctl,
    input  side_ctl_t    far_ctl,
    input  logic [W-1:0] near_in,
    input  logic [W-1:0] far_in,
    input  logic [W-1:0] near_keep,
    input  logic [W-1:0] far_keep,
    input  logic [W-1:0] near_reg,
    input  logic [W-1:0] far_reg,
    output logic [W-1:0] bus
);

    // The far bus as seen through a live path, expanded once so that
    // no combinational path runs through the block's own outputs.
    logic [W-1:0] far_view;

    always_comb begin
        if (far_ctl.ext_en) begin
            far_view = far_in;
        end else if (!far_ctl.drive_en) begin
            far_view = far_keep;
        end else if (near_ctl.sel == SRC_STORED) begin
            far_view = near_reg;
        end else begin
            // closed loop with no outside driver: bus holds its value
            far_view = near_keep;
        end
    end

    always_comb begin
        if (near_ctl.ext_en) begin
            bus = near_in;
        end else if (!near_ctl.drive_en) begin
            bus = near_keep;
        end else if (far_ctl.sel == SRC_STORED) begin
            bus = far_reg;
        end else begin
            bus = far_view;
        end
    end

endmodule

// File: rtl/dxr_path_mux.sv
module dxr_path_mux
    import dxr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  src_sel_e     sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    // Plain two-way choice: every output bit comes from exactly one source
    always_comb begin
        unique case (sel)
            SRC_STORED: y = stored;
            default:    y = live;
        endcase
    end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import dxr_pkg::*;
#(
    parameter int unsigned WIDTH = DXR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             en_ab,
    input  logic             en_ba_n,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_ext_en,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_ext_en,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    side_ctl_t        ctl     [NUM_SIDES];
    logic             cap_clk [NUM_SIDES];
    logic [WIDTH-1:0] in_v    [NUM_SIDES];
    logic [WIDTH-1:0] bus_v   [NUM_SIDES];
    logic [WIDTH-1:0] keep_v  [NUM_SIDES];
    logic [WIDTH-1:0] reg_v   [NUM_SIDES];
    logic [WIDTH-1:0] out_v   [NUM_SIDES];
    logic [WIDTH-1:0] a_bus_w;
    logic [WIDTH-1:0] b_bus_w;

    assign ctl[SIDE_A].ext_en   = a_ext_en;
    assign ctl[SIDE_A].drive_en = ~en_ba_n;
    assign ctl[SIDE_A].sel      = src_sel_e'(sel_ab);
    assign ctl[SIDE_B].ext_en   = b_ext_en;
    assign ctl[SIDE_B].drive_en = en_ab;
    assign ctl[SIDE_B].sel      = src_sel_e'(sel_ba);

    assign cap_clk[SIDE_A] = clk_ab;
    assign cap_clk[SIDE_B] = clk_ba;
    assign in_v[SIDE_A]    = a_in;
    assign in_v[SIDE_B]    = b_in;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int unsigned FAR = far_side(s);

        // bus resolution for this side
        dxr_resolve #(.W(WIDTH)) u_resolve (
            .near_ctl  (ctl[s]),
            .far_ctl   (ctl[FAR]),
            .near_in   (in_v[s]),
            .far_in    (in_v[FAR]),
            .near_keep (keep_v[s]),
            .far_keep  (keep_v[FAR]),
            .near_reg  (reg_v[s]),
            .far_reg   (reg_v[FAR]),
            .bus       (bus_v[s])
        );

        // hold value of this bus, sampled every cycle
        dxr_capture #(.W(WIDTH)) u_keep (
            .clk (clk),
            .rst (rst),
            .d   (bus_v[s]),
            .q   (keep_v[s])
        );

        // storage register loaded from this bus on its own clock
        dxr_capture #(.W(WIDTH)) u_store (
            .clk (cap_clk[s]),
            .rst (rst),
            .d   (bus_v[s]),
            .q   (reg_v[s])
        );

        // path from this bus to the opposite one
        dxr_path_mux #(.W(WIDTH)) u_mux (
            .sel    (ctl[s].sel),
            .live   (bus_v[s]),
            .stored (reg_v[s]),
            .y      (out_v[FAR])
        );
    end

    assign a_out   = out_v[SIDE_A];
    assign b_out   = out_v[SIDE_B];
    assign a_oe    = ctl[SIDE_A].drive_en;
    assign b_oe    = ctl[SIDE_B].drive_en;
    assign a_bus_w = bus_v[SIDE_A];
    assign b_bus_w = bus_v[SIDE_B];

endmodule

// File: rtl/dxr_checker.sv
module dxr_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         a_ext_en,
    input logic         b_ext_en,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] a_bus,
    input logic [W-1:0] b_bus
);

    logic [W-1:0] shadow_a;
    logic [W-1:0] shadow_b;
    logic         loop_c;
    logic         hold_c;

    always_ff @(posedge clk_ab) shadow_a <= rst ? '0 : a_bus;
    always_ff @(posedge clk_ba) shadow_b <= rst ? '0 : b_bus;

    assign loop_c = !sel_ab && !sel_ba && a_oe && b_oe;
    assign hold_c = loop_c && !a_ext_en && !b_ext_en;

    a_r1_stored_ab: assert property (@(posedge clk) disable iff (rst)
        sel_ab |-> (b_out == shadow_a));

    a_r2_stored_ba: assert property (@(posedge clk) disable iff (rst)
        sel_ba |-> (a_out == shadow_b));

    a_r4_live_ab: assert property (@(posedge clk) disable iff (rst)
        (!sel_ab && a_ext_en) |-> (b_out == a_in));

    a_r5_live_ba: assert property (@(posedge clk) disable iff (rst)
        (!sel_ba && b_ext_en) |-> (a_out == b_in));

    a_r7_loop_hold: assert property (@(posedge clk) disable iff (rst)
        (hold_c && $past(hold_c)) |-> ($stable(a_out) && $stable(b_out)));

    a_r8_loop_follow_a: assert property (@(posedge clk) disable iff (rst)
        (loop_c && a_ext_en && !b_ext_en) |-> (a_out == a_in && b_out == a_in));

    a_r8_loop_follow_b: assert property (@(posedge clk) disable iff (rst)
        (loop_c && b_ext_en && !a_ext_en) |-> (a_out == b_in && b_out == b_in));

endmodule

bind dual_reg_xcvr dxr_checker #(.W(WIDTH)) u_dxr_checker (
    .clk      (clk),
    .rst      (rst),
    .clk_ab   (clk_ab),
    .clk_ba   (clk_ba),
    .sel_ab   (sel_ab),
    .sel_ba   (sel_ba),
    .a_ext_en (a_ext_en),
    .b_ext_en (b_ext_en),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_out    (a_out),
    .b_out    (b_out),
    .a_oe     (a_oe),
    .b_oe     (b_oe),
    .a_bus    (a_bus_w),
    .b_bus    (b_bus_w)
);

// File: tb/test_dual_reg_xcvr.sv
module test_dual_reg_xcvr;

    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic         a_oe;
        logic         b_oe;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clk_ab = 1'b0, clk_ba = 1'b0;
    logic         en_ab = 1'b0, en_ba_n = 1'b1;
    logic         sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_ext_en = 1'b0, b_ext_en = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // next-step stimulus, applied inside the driver task
    bit         n_rst = 1, n_en_ab = 0, n_en_ba_n = 1, n_sel_ab = 0, n_sel_ba = 0;
    bit         n_a_ext = 0, n_b_ext = 0;
    logic [W-1:0] n_a_in = '0, n_b_in = '0;

    // reference state
    bit         m_rst = 1;
    logic [W-1:0] m_bus_a = '0, m_bus_b = '0, m_ra = '0, m_rb = '0;
    logic [W-1:0] m_ka = '0, m_kb = '0;

    always #10 clk = ~clk;  // 50 MHz

    dual_reg_xcvr #(.WIDTH(W)) i_dual_reg_xcvr (
        .clk(clk), .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_ext_en(a_ext_en), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_ext_en(b_ext_en), .b_out(b_out), .b_oe(b_oe)
    );

    // Bus value from the requirements: outside driver, else block drive, else hold
    function automatic logic [W-1:0] bus_of(
        bit ne, logic [W-1:0] ni, bit nd, logic [W-1:0] nk, logic [W-1:0] nr, bit ns,
        bit fe, logic [W-1:0] fi, bit fd, logic [W-1:0] fk, logic [W-1:0] fr, bit fs);
        if (ne) return ni;
        if (!nd) return nk;
        if (fs) return fr;
        if (fe) return fi;
        if (!fd) return fk;
        if (ns) return nr;
        return nk;
    endfunction

    task automatic model_buses();
        m_bus_a = bus_of(n_a_ext, n_a_in, !n_en_ba_n, m_ka, m_ra, n_sel_ab,
                         n_b_ext, n_b_in, n_en_ab, m_kb, m_rb, n_sel_ba);
        m_bus_b = bus_of(n_b_ext, n_b_in, n_en_ab, m_kb, m_rb, n_sel_ba,
                         n_a_ext, n_a_in, !n_en_ba_n, m_ka, m_ra, n_sel_ab);
    endtask

    task automatic step(bit cab, bit cba, string tag);
        exp_t e;
        @(posedge clk);
        #2;
        if (m_rst) begin m_ka = '0; m_kb = '0; end
        else       begin m_ka = m_bus_a; m_kb = m_bus_b; end
        m_rst = n_rst;
        rst = n_rst; en_ab = n_en_ab; en_ba_n = n_en_ba_n;
        sel_ab = n_sel_ab; sel_ba = n_sel_ba;
        a_in = n_a_in; b_in = n_b_in; a_ext_en = n_a_ext; b_ext_en = n_b_ext;
        clk_ab = 1'b0; clk_ba = 1'b0;
        model_buses();
        #4;
        clk_ab = cab; clk_ba = cba;
        begin
            logic [W-1:0] pa, pb;
            pa = m_bus_a; pb = m_bus_b;
            if (cab) m_ra = n_rst ? '0 : pa;
            if (cba) m_rb = n_rst ? '0 : pb;
        end
        model_buses();
        e.a_out = n_sel_ba ? m_rb : m_bus_b;
        e.b_out = n_sel_ab ? m_ra : m_bus_a;
        e.a_oe  = !n_en_ba_n;
        e.b_oe  = n_en_ab;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (a_out !== e.a_out || b_out !== e.b_out || a_oe !== e.a_oe || b_oe !== e.b_oe) begin
                    bad++;
                    $display("FAIL %s: actual a_out=%h b_out=%h a_oe=%b b_oe=%b expected a_out=%h b_out=%h a_oe=%b b_oe=%b",
                             t, a_out, b_out, a_oe, b_oe, e.a_out, e.b_out, e.a_oe, e.b_oe);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R3: reset clears registers and hold values
        n_rst = 1; n_a_ext = 1; n_a_in = 8'hFF; n_b_ext = 1; n_b_in = 8'hEE;
        step(1, 1, "R3");
        step(1, 1, "R3");
        n_rst = 0; n_a_ext = 0; n_b_ext = 0; n_sel_ab = 1; n_sel_ba = 1;
        n_en_ab = 0; n_en_ba_n = 1;
        step(0, 0, "R3");
        step(0, 0, "R3");

        // R1: capture A with live select, then show stored value
        n_sel_ab = 0; n_a_ext = 1; n_a_in = 8'h5A;
        step(1, 0, "R1");
        n_sel_ab = 1; n_a_in = 8'h33;
        step(0, 0, "R1");
        // R9: live A changes without a capture edge
        n_a_in = 8'hC0; step(0, 0, "R9");
        n_a_in = 8'h01; step(0, 0, "R9");
        // R1: capture while stored select is active
        n_a_in = 8'hA7; step(1, 0, "R1");
        n_a_in = 8'h00; step(0, 0, "R1");

        // R2: capture B, stored and live selects
        n_b_ext = 1; n_b_in = 8'h6C; n_sel_ba = 1;
        step(0, 1, "R2");
        n_b_in = 8'h12; step(0, 0, "R9");
        n_sel_ba = 0; n_b_in = 8'h3D; step(0, 1, "R2");
        n_sel_ba = 1; n_b_in = 8'h99; step(0, 0, "R2");

        // R4 R5 R6: all select and enable combinations, both buses driven
        for (int c = 0; c < 16; c++) begin
            n_sel_ab = c[0]; n_sel_ba = c[1]; n_en_ab = c[2]; n_en_ba_n = c[3];
            n_a_ext = 1; n_b_ext = 1;
            n_a_in = 8'hC3 ^ 8'(c); n_b_in = 8'h3C ^ 8'(c << 4);
            step(0, 0, "R4/R5/R6");
        end

        // R8: loop mode, A driven from outside
        n_sel_ab = 0; n_sel_ba = 0; n_en_ab = 1; n_en_ba_n = 0;
        n_a_ext = 1; n_a_in = 8'h96; n_b_ext = 0;
        step(0, 0, "R8");
        step(0, 0, "R8");
        // R7: release, both buses hold
        n_a_ext = 0; n_a_in = 8'h00;
        step(0, 0, "R7");
        step(0, 0, "R7");
        step(0, 0, "R7");
        // R8: B driven from outside
        n_b_ext = 1; n_b_in = 8'h21;
        step(0, 0, "R8");
        // R7: release again
        n_b_ext = 0; n_b_in = 8'hFF;
        step(0, 0, "R7");
        step(0, 0, "R7");
        // R1 R2: capture held loop values
        step(1, 1, "R1");
        n_sel_ab = 1; n_sel_ba = 1; n_a_ext = 1; n_b_ext = 1; n_a_in = 8'h44; n_b_in = 8'h55;
        step(0, 0, "R2");

        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule